// File: doc/BRIEF.md
# APB Write Bridge into a Slow Asynchronous Clock Domain

This block is an APB slave that sits on a fast bus clock and hands register writes to processing logic on a much slower clock that has no fixed phase relation to it. The bus has no wait-state signal, so every transfer ends after its setup and access cycles. The bridge therefore cannot hold off the master. It captures each write's address and data into a small dual-clock queue whose pointers cross the domains in Gray code. The slow side drains the queue at one entry per slow cycle and raises a single-cycle write strobe for each entry it delivers.

Software paces itself by reading a status word. The word holds the queue fill level as the bus side sees it, together with a sticky flag that records a write lost because the queue was full. A second read location returns status bits from the slow domain after a two-flop synchronizer. Each clock domain has its own reset synchronizer. Both are fed from the AND of the two reset inputs, so either reset clears the whole bridge, including both queue pointers.

Top module: `apb_wr_bridge`

## Requirements
- R1: A write transfer (psel, penable and pwrite high in the access cycle) is delivered exactly once on the slow side: wr_stb is high for one slow cycle per delivered write, with wr_addr and wr_data equal to the captured paddr and pwdata. wr_addr and wr_data hold their values in every slow cycle without a strobe.
- R2: Writes issued back to back, each setup cycle directly after the previous access cycle, are all delivered in issue order, provided no more than DEPTH of them are outstanding.
- R3: A read with paddr[2]=0 returns the level word. Bits [DEPTH_LOG2:0] hold the number of queued entries as seen from the bus clock; it is 0 once the queue has drained.
- R4: A write that arrives while the level equals DEPTH is discarded and never delivered. It sets the overflow flag, which is bit 16 of the level word.
- R5: The overflow flag stays set until a read of the level word. That read returns 1 in bit 16 and clears the flag. If a discarded write and the clearing read fall in the same cycle, the flag stays set.
- R6: A read with paddr[2]=1 returns proc_stat, taken through a two-flop synchronizer in the bus clock and zero-extended to DW bits.
- R7: Read transfers never place an entry in the queue and never produce a strobe.
- R8: A low level on presetn or srstn clears both queue pointers, the level and the overflow flag. Entries still queued at that moment are never delivered.
- R9: Each Gray-coded queue pointer changes in at most one bit per clock of its own domain.
- R10: Out of reset, the level word reads 0 and wr_stb is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Bus-side asynchronous reset, active low |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | AW | Transfer address; bit 2 selects the read location |
| pwdata | input | DW | Write data |
| prdata | output | DW | Read data, valid while psel is high and pwrite is low |
| sclk | input | 1 | Processing clock |
| srstn | input | 1 | Processing-side asynchronous reset, active low |
| wr_stb | output | 1 | One-cycle strobe per delivered write |
| wr_addr | output | AW | Address of the delivered write |
| wr_data | output | DW | Data of the delivered write |
| proc_stat | input | SW | Status bits from the processing domain |

## Verification
On every cycle, the assertions check several invariants. Each Gray pointer moves by at most one bit per clock. The bus-side level never exceeds the queue depth, and a read transfer never raises it. The overflow flag sets on a write into a full queue and stays set until a level read. The delivered address and data hold steady between strobes. End-to-end behaviour needs the bench's scenarios, because it depends on the two clocks together. This covers lossless ordered delivery of back-to-back bursts, the discard of exactly the write that met a full queue, read-to-clear, the synchronized slow status value, and the flushing effect of a reset from either side. The bench stops the slow clock to fill the queue to a known state.

// File: rtl/apb_br_pkg.sv
package apb_br_pkg;
  // address bit that chooses between the two read locations
  localparam int RSEL_BIT = 2;
  // bit of the level word that carries the sticky overflow flag
  localparam int OVF_BIT  = 16;

  typedef enum logic {
    RSEL_LEVEL    = 1'b0,
    RSEL_SLOWSTAT = 1'b1
  } rsel_e;
endpackage

// File: rtl/br_rst_sync.sv
module br_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] stg;

  // assert at once, release after two local clock edges
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg <= 2'b00;
    else         stg <= {stg[0], 1'b1};
  end

  assign rst_n = stg[1];
endmodule

// File: rtl/br_sync2.sv
module br_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/br_async_fifo.sv
module br_async_fifo #(
  parameter int EW         = 44,
  parameter int DEPTH_LOG2 = 2
) (
  input  logic            wclk,
  input  logic            wrst_n,
  input  logic            push,
  input  logic [EW-1:0]   wdata,
  output logic            full,
  output logic [DEPTH_LOG2:0] level,
  input  logic            rclk,
  input  logic            rrst_n,
  input  logic            pop,
  output logic [EW-1:0]   rdata,
  output logic            empty
);
  localparam int PW    = DEPTH_LOG2 + 1;
  localparam int DEPTH = 1 << DEPTH_LOG2;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] occupancy(input logic [PW-1:0] wb,
                                              input logic [PW-1:0] rb);
    return wb - rb;
  endfunction

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rgray_w, wgray_r;
  logic          push_ok;

  // ---------------- write side ----------------
  br_sync2 #(.W(PW)) u_rptr_sync (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w)
  );

  assign level   = occupancy(wbin, from_gray(rgray_w));
  assign full    = level[DEPTH_LOG2];
  assign push_ok = push & ~full;

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (push_ok) begin
      wbin  <= wbin + 1'b1;
      wgray <= to_gray(wbin + 1'b1);
    end
  end

  always_ff @(posedge wclk) begin
    if (push_ok) mem[wbin[DEPTH_LOG2-1:0]] <= wdata;
  end

  // ---------------- read side ----------------
  br_sync2 #(.W(PW)) u_wptr_sync (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r)
  );

  assign empty = (rgray == wgray_r);
  assign rdata = mem[rbin[DEPTH_LOG2-1:0]];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (pop && !empty) begin
      rbin  <= rbin + 1'b1;
      rgray <= to_gray(rbin + 1'b1);
    end
  end

  // ---------------- assertions ----------------
  a_r9_wgray_onestep: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  a_r9_rgray_onestep: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1);

  a_r4_level_bound: assert property (@(posedge wclk) disable iff (!wrst_n)
    level <= PW'(DEPTH));
endmodule

// File: rtl/apb_wr_bridge.sv
module apb_wr_bridge
  import apb_br_pkg::*;
#(
  parameter int AW         = 12,
  parameter int DW         = 32,
  parameter int DEPTH_LOG2 = 2,
  parameter int SW         = 8
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  input  logic          sclk,
  input  logic          srstn,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic [SW-1:0] proc_stat
);
  localparam int EW = AW + DW;
  localparam int LW = DEPTH_LOG2 + 1;

  // ---------------- resets ----------------
  logic raw_rst_n, p_rst_n, s_rst_n;
  assign raw_rst_n = presetn & srstn;

  br_rst_sync u_prst (.clk(pclk), .arst_n(raw_rst_n), .rst_n(p_rst_n));
  br_rst_sync u_srst (.clk(sclk), .arst_n(raw_rst_n), .rst_n(s_rst_n));

  // ---------------- bus-side events ----------------
  logic  push_req, lvl_rd, q_full, q_empty, pop;
  logic  [LW-1:0] q_level;
  logic  [EW-1:0] q_rdata;
  rsel_e rsel;

  assign rsel     = rsel_e'(paddr[RSEL_BIT]);
  assign push_req = psel & penable & pwrite;
  assign lvl_rd   = psel & penable & ~pwrite & (rsel == RSEL_LEVEL);

  br_async_fifo #(.EW(EW), .DEPTH_LOG2(DEPTH_LOG2)) u_fifo (
    .wclk  (pclk),
    .wrst_n(p_rst_n),
    .push  (push_req),
    .wdata ({paddr, pwdata}),
    .full  (q_full),
    .level (q_level),
    .rclk  (sclk),
    .rrst_n(s_rst_n),
    .pop   (pop),
    .rdata (q_rdata),
    .empty (q_empty)
  );

  // ---------------- sticky overflow ----------------
  logic ovf;
  always_ff @(posedge pclk or negedge p_rst_n) begin
    if (!p_rst_n)               ovf <= 1'b0;
    else if (push_req & q_full) ovf <= 1'b1;
    else if (lvl_rd)            ovf <= 1'b0;
  end

  // ---------------- slow status into bus clock ----------------
  logic [SW-1:0] stat_p;
  br_sync2 #(.W(SW)) u_stat_sync (
    .clk(pclk), .rst_n(p_rst_n), .d(proc_stat), .q(stat_p)
  );

  // ---------------- read mux ----------------
  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (rsel == RSEL_LEVEL) begin
        prdata[LW-1:0]  = q_level;
        prdata[OVF_BIT] = ovf;
      end else begin
        prdata[SW-1:0]  = stat_p;
      end
    end
  end

  // ---------------- slow-side delivery ----------------
  assign pop = ~q_empty;

  always_ff @(posedge sclk or negedge s_rst_n) begin
    if (!s_rst_n) begin
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= pop;
      if (pop) {wr_addr, wr_data} <= q_rdata;
    end
  end

  // ---------------- assertions ----------------
  a_r4_ovf_set: assert property (@(posedge pclk) disable iff (!p_rst_n)
    (push_req && q_full) |=> ovf);

  a_r5_ovf_sticky: assert property (@(posedge pclk) disable iff (!p_rst_n)
    (ovf && !lvl_rd) |=> ovf);

  a_r7_read_no_fill: assert property (@(posedge pclk) disable iff (!p_rst_n)
    (psel && !pwrite) |=> (q_level <= $past(q_level)));

  a_r1_out_hold: assert property (@(posedge sclk) disable iff (!s_rst_n)
    !wr_stb |-> ($stable(wr_addr) && $stable(wr_data)));
endmodule

// File: tb/apb_wr_bridge_bench.sv
module apb_wr_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SHALF      = 23;
  localparam int AW = 12, DW = 32, DEPTH_LOG2 = 2, SW = 8;
  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic pclk = 0, sclk = 0, sclk_run = 1;
  logic presetn = 0, srstn = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [DW-1:0] prdata;
  logic wr_stb;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [SW-1:0] proc_stat = '0;

  int n_chk = 0, n_bad = 0;
  int got_n = 0;
  logic [AW-1:0] got_a [64];
  logic [DW-1:0] got_d [64];
  logic [AW-1:0] exp_a [64];
  logic [DW-1:0] exp_d [64];
  int exp_n;
  logic [DW-1:0] rd_val;

  always #(CLK_PERIOD/2) pclk = ~pclk;
  always #(SHALF) if (sclk_run) sclk = ~sclk;

  apb_wr_bridge #(.AW(AW), .DW(DW), .DEPTH_LOG2(DEPTH_LOG2), .SW(SW)) u_apb_wr_bridge (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .sclk(sclk), .srstn(srstn), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .proc_stat(proc_stat)
  );

  // slow-side monitor, sampled away from the active edge
  always @(negedge sclk) begin
    if (wr_stb && got_n < 64) begin
      got_a[got_n] = wr_addr;
      got_d[got_n] = wr_data;
      got_n++;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic pwait(input int n);
    repeat (n) @(posedge pclk);
    #1;
  endtask

  // callers stand 1 ns after a pclk edge; consecutive calls are back to back
  task automatic apb_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(posedge pclk); #1 penable = 1;
    @(posedge pclk); #1 psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [AW-1:0] a);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(posedge pclk); #1 penable = 1;
    #3 rd_val = prdata;
    @(posedge pclk); #1 psel = 0; penable = 0;
  endtask

  task automatic queue_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit keep);
    apb_wr(a, d);
    if (keep) begin
      exp_a[exp_n] = a;
      exp_d[exp_n] = d;
      exp_n++;
    end
  endtask

  task automatic check_delivered(input string req, input int base);
    chk(req, "delivered count", got_n - base, exp_n);
    for (int i = 0; i < exp_n && base + i < got_n; i++) begin
      chk(req, "delivered addr", got_a[base+i], exp_a[i]);
      chk(req, "delivered data", got_d[base+i], exp_d[i]);
    end
  endtask

  task automatic t_reset_state;
    pwait(1);
    chk("R10", "strobe out of reset", wr_stb, 0);
    apb_rd(12'h000);
    chk("R10", "level word out of reset", rd_val, 0);
  endtask

  task automatic t_single;
    int base = got_n;
    exp_n = 0;
    pwait(1);
    queue_wr(12'h3A4, 32'hDEAD_BEEF, 1);
    pwait(60);
    check_delivered("R1", base);
    apb_rd(12'h000);
    chk("R3", "level after drain", rd_val, 0);
  endtask

  task automatic t_burst;
    int base = got_n;
    exp_n = 0;
    pwait(1);
    for (int i = 0; i < DEPTH; i++) queue_wr(AW'(12'h100 + i*4), 32'hA000_0000 + i, 1);
    pwait(60);
    check_delivered("R2", base);
    apb_rd(12'h000);
    chk("R2", "no overflow after burst", rd_val, 0);
  endtask

  task automatic t_overflow;
    int base = got_n;
    exp_n = 0;
    pwait(1);
    sclk_run = 0;
    pwait(4);
    for (int i = 0; i < DEPTH; i++) queue_wr(AW'(12'h200 + i*4), 32'h5500_0000 + i, 1);
    apb_rd(12'h000);
    chk("R3", "level when full", rd_val, DEPTH);
    queue_wr(12'h2FC, 32'hBAD0_BAD0, 0);
    apb_rd(12'h000);
    chk("R4", "overflow flag and level", rd_val, (32'h1 << 16) | DEPTH);
    apb_rd(12'h000);
    chk("R5", "flag cleared by read", rd_val, DEPTH);
    sclk_run = 1;
    pwait(60);
    check_delivered("R4", base);
    apb_rd(12'h000);
    chk("R3", "level after drain", rd_val, 0);
  endtask

  task automatic t_paced;
    int base = got_n;
    exp_n = 0;
    pwait(1);
    for (int i = 0; i < 12; i++) begin
      queue_wr(AW'(12'h400 + i*8), {16'hC0DE, 16'(i * 37)}, 1);
      pwait(12);
    end
    pwait(60);
    check_delivered("R1", base);
  endtask

  task automatic t_slow_status;
    proc_stat = 8'hA5;
    pwait(5);
    apb_rd(12'h004);
    chk("R6", "slow status A5", rd_val, 32'hA5);
    proc_stat = 8'h3C;
    pwait(5);
    apb_rd(12'h004);
    chk("R6", "slow status 3C", rd_val, 32'h3C);
  endtask

  task automatic t_reads_only;
    int base = got_n;
    pwait(1);
    for (int i = 0; i < 6; i++) apb_rd(AW'(i*4));
    apb_rd(12'h000);
    chk("R7", "level after reads", rd_val, 0);
    pwait(60);
    chk("R7", "no strobes from reads", got_n - base, 0);
  endtask

  task automatic t_reset_clears(input bit bus_side);
    int base = got_n;
    pwait(1);
    sclk_run = 0;
    pwait(4);
    queue_wr(12'h600, 32'h1111_1111, 0);
    queue_wr(12'h604, 32'h2222_2222, 0);
    queue_wr(12'h608, 32'h3333_3333, 0);
    queue_wr(12'h60C, 32'h4444_4444, 0);
    queue_wr(12'h610, 32'h5555_5555, 0);
    if (bus_side) presetn = 0; else srstn = 0;
    sclk_run = 1;
    pwait(20);
    presetn = 1; srstn = 1;
    pwait(20);
    apb_rd(12'h000);
    chk("R8", bus_side ? "level word after bus reset" : "level word after slow reset", rd_val, 0);
    pwait(60);
    chk("R8", "flushed entries not delivered", got_n - base, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL R1 watchdog: actual timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    pwait(5);
    presetn = 1; srstn = 1;
    pwait(20);
    t_reset_state;
    t_single;
    t_burst;
    t_overflow;
    t_paced;
    t_slow_status;
    t_reads_only;
    t_reset_clears(0);
    t_reset_clears(1);
    t_single;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule